// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps the time of day and the calendar as packed BCD bytes. Its own prescaler counts an oscillator-rate enable. Once every `PRESCALE` enabled ticks it advances seconds, minutes, hours, day of week, date, month and a two-digit year. Each carry ripples into the next field, and all fields change on the same clock edge. Hours run in either 24-hour or 12-hour form, chosen by a bit inside the hours byte. Month length follows the month, and February takes leap years into account. A century flag in the month byte flips when the year wraps.

A host write port loads any single field for one cycle. It is a plain strobe with no back-pressure: every write is taken in the cycle it is presented. Writing the seconds field restarts the prescaler, so the following second starts at the write. Two outputs serve logic further down the chip. A 1 Hz square wave is low for the first half of each second and high for the second half. A one-cycle update strobe marks the cycle in which freshly advanced fields first appear, and downstream alarm logic uses it.

Top module: `bcd_rtc_counter`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 0x00 (24-hour midnight), day of week 01, date 01, month 0x01 (century flag 0), year 00, with `sq_1hz` and `sec_strobe` low.
- R2: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R3: In 24-hour mode (hours bit 6 = 0) hours count 00 to 23, with bit 5 as the tens-of-hours bit for 20 to 23. The step from 23:59:59 gives 00:00:00 and advances the calendar by one day.
- R4: In 12-hour mode (hours bit 6 = 1) bits 4:0 hold BCD 01 to 12 and bit 5 is 1 for PM. The sequence runs 11 AM to 12 PM to 01 PM and 11 PM to 12 AM. Only the step from 11 PM to 12 AM advances the calendar. Bit 6 is kept.
- R5: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 for all other months. A year counts as a leap year when its BCD value is divisible by 4, and year 00 is a leap year.
- R6: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and inverts bit 7 of the month byte (the century flag). Bits 4:0 of the month byte hold the month number.
- R7: Day of week advances once per calendar day and runs through 1 to 7, with 7 followed by 1.
- R8: The fields advance once per `PRESCALE` cycles in which `osc_tick` is high. Cycles with `osc_tick` low do not count.
- R9: A write with `wr_en` high stores `wr_data` in the field selected by `wr_field`, and the new value is visible from the next cycle. The field codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. If a second ends in a write cycle, that advance and its strobe are dropped.
- R10: A write to seconds restarts the prescaler at zero. The next advance comes `PRESCALE` ticks later, and `sq_1hz` rises `PRESCALE/2` ticks after the write.
- R11: `sq_1hz` is low for the first `PRESCALE/2` ticks of each second and high for the rest of the second.
- R12: `sec_strobe` is high for exactly one cycle per advance. That cycle is the first one that shows the advanced fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator-rate count enable |
| wr_en | input | 1 | Host write strobe |
| wr_field | input | 3 | Field code for the write |
| wr_data | input | 8 | Packed BCD value to load |
| sec_bcd | output | 8 | Seconds |
| min_bcd | output | 8 | Minutes |
| hour_bcd | output | 8 | Hours with mode and AM/PM bits |
| dow_bcd | output | 8 | Day of week |
| date_bcd | output | 8 | Date of month |
| month_bcd | output | 8 | Month, century flag in bit 7 |
| year_bcd | output | 8 | Two-digit year |
| sq_1hz | output | 1 | Half-second-phased 1 Hz square wave |
| sec_strobe | output | 1 | One-cycle update strobe |

## Verification
The hardest situations to reach are the rare carry chains: a leap-day February, a year wrap that flips the century flag, and the 11 PM to 12 AM step in 12-hour mode. Counting up to any of them would take a simulated year. The bench instead loads the moment just before each boundary through the write port, with the seconds write last, and runs a small prescaler for two seconds. It also times a minutes write to land in the exact cycle a second ends. The behavioural reference model follows these cases cycle by cycle, including the dropped advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } rtc_field_e;

  // increment of a two-digit packed BCD value (no upper-digit wrap)
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // a BCD year is divisible by 4 when an even tens digit meets units 0/4/8
  // or an odd tens digit meets units 2/6
  function automatic logic bcd_leap(input logic tens_odd, input logic [3:0] units);
    if (tens_odd) return (units == 4'd2) || (units == 4'd6);
    return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
  endfunction

  function automatic logic [5:0] bcd_month_end(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic restart,
  output logic sec_tick,
  output logic half_phase
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
  localparam logic [CW-1:0] HALF = CW'(PRESCALE / 2);

  logic [CW-1:0] cnt;

  assign sec_tick   = tick_en && (cnt == LAST) && !restart;
  assign half_phase = (cnt >= HALF);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= '0;
    else if (tick_en)      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/rtc_time_of_day.sv
module rtc_time_of_day
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       day_adv
);
  logic       sec_wrap, min_wrap, hour_wrap;
  logic [7:0] hour_next;

  assign sec_wrap = (sec == 8'h59);
  assign min_wrap = (min == 8'h59);

  // hour successor and end-of-day detection for both modes
  always_comb begin
    if (hour[6]) begin
      hour_wrap = (hour[4:0] == 5'h11) && hour[5];
      if (hour[4:0] == 5'h11)      hour_next = {2'b01, ~hour[5], 5'h12};
      else if (hour[4:0] == 5'h12) hour_next = {2'b01, hour[5], 5'h01};
      else                         hour_next = {2'b01, hour[5], 5'h00} | bcd_inc8({3'b000, hour[4:0]});
    end else begin
      hour_wrap = (hour[5:0] == 6'h23);
      hour_next = hour_wrap ? 8'h00 : bcd_inc8({2'b00, hour[5:0]});
    end
  end

  assign day_adv = adv && sec_wrap && min_wrap && hour_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else if (wr_en) begin
      if (wr_field == FLD_SEC)  sec  <= wr_data;
      if (wr_field == FLD_MIN)  min  <= wr_data;
      if (wr_field == FLD_HOUR) hour <= wr_data;
    end else if (adv) begin
      sec <= sec_wrap ? 8'h00 : bcd_inc8(sec);
      if (sec_wrap) begin
        min <= min_wrap ? 8'h00 : bcd_inc8(min);
        if (min_wrap) hour <= hour_next;
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_adv,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year
);
  logic       leap;
  logic [5:0] month_end;
  logic       date_wrap, month_wrap, year_wrap;

  assign leap       = bcd_leap(year[4], year[3:0]);
  assign month_end  = bcd_month_end(month[4:0], leap);
  assign date_wrap  = (date[5:0] == month_end);
  assign month_wrap = (month[4:0] == 5'h12);
  assign year_wrap  = (year == 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow   <= 8'h01;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else if (wr_en) begin
      if (wr_field == FLD_DOW)   dow   <= wr_data;
      if (wr_field == FLD_DATE)  date  <= wr_data;
      if (wr_field == FLD_MONTH) month <= wr_data;
      if (wr_field == FLD_YEAR)  year  <= wr_data;
    end else if (day_adv) begin
      dow  <= (dow == 8'h07) ? 8'h01 : bcd_inc8(dow);
      date <= date_wrap ? 8'h01 : bcd_inc8(date);
      if (date_wrap) begin
        month[4:0] <= month_wrap ? 5'h01 : month[4:0] + 5'h01 + ((month[3:0] == 4'h9) ? 5'h06 : 5'h00);
        if (month_wrap) begin
          year <= year_wrap ? 8'h00 : bcd_inc8(year);
          if (year_wrap) month[7] <= ~month[7];
        end
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] hour_bcd,
  output logic [7:0] dow_bcd,
  output logic [7:0] date_bcd,
  output logic [7:0] month_bcd,
  output logic [7:0] year_bcd,
  output logic       sq_1hz,
  output logic       sec_strobe
);
  logic sec_write, sec_tick, adv, day_adv;

  assign sec_write = wr_en && (wr_field == FLD_SEC);
  assign adv       = sec_tick && !wr_en;

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (osc_tick),
    .restart    (sec_write),
    .sec_tick   (sec_tick),
    .half_phase (sq_1hz)
  );

  rtc_time_of_day u_tod (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .wr_en    (wr_en),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .sec      (sec_bcd),
    .min      (min_bcd),
    .hour     (hour_bcd),
    .day_adv  (day_adv)
  );

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_adv  (day_adv),
    .wr_en    (wr_en),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .dow      (dow_bcd),
    .date     (date_bcd),
    .month    (month_bcd),
    .year     (year_bcd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sec_strobe <= 1'b0;
    else        sec_strobe <= adv;
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_field,
  input logic [7:0] sec_bcd,
  input logic [7:0] dow_bcd,
  input logic [7:0] month_bcd,
  input logic [7:0] year_bcd,
  input logic       sq_1hz,
  input logic       sec_strobe
);
  a_r2_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && $past(sec_bcd) == 8'h59) |-> sec_bcd == 8'h00);

  a_r6_century_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && $past(year_bcd) == 8'h99 && year_bcd == 8'h00) |-> month_bcd[7] != $past(month_bcd[7]));

  a_r7_dow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_strobe && !$past(wr_en)) |-> $stable(dow_bcd));

  a_r10_sq_low_after_sec_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_field) == 3'd0) |-> !sq_1hz);

  a_r11_second_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> !sq_1hz);

  a_r12_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |=> !sec_strobe);
endmodule

bind bcd_rtc_counter rtc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_field   (wr_field),
  .sec_bcd    (sec_bcd),
  .dow_bcd    (dow_bcd),
  .month_bcd  (month_bcd),
  .year_bcd   (year_bcd),
  .sq_1hz     (sq_1hz),
  .sec_strobe (sec_strobe)
);

// File: tb/bcd_rtc_counter_tb.sv
`timescale 1ns/1ps
module bcd_rtc_counter_tb;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_field = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_bcd, min_bcd, hour_bcd, dow_bcd, date_bcd, month_bcd, year_bcd;
  logic       sq_1hz, sec_strobe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bcd_rtc_counter #(.PRESCALE(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
    .wr_field(wr_field), .wr_data(wr_data), .sec_bcd(sec_bcd),
    .min_bcd(min_bcd), .hour_bcd(hour_bcd), .dow_bcd(dow_bcd),
    .date_bcd(date_bcd), .month_bcd(month_bcd), .year_bcd(year_bcd),
    .sq_1hz(sq_1hz), .sec_strobe(sec_strobe)
  );

  // ---------------- behavioural reference model ----------------
  int ms, mm, mh, mdow, mdate, mmon, myear, pc;
  bit m12, mcent, msq, mstb;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] exp_hour();
    int h12;
    if (!m12) return i2b(mh);
    h12 = (mh % 12 == 0) ? 12 : mh % 12;
    return 8'h40 | ((mh >= 12) ? 8'h20 : 8'h00) | i2b(h12);
  endfunction

  task automatic model_advance();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh = (mh + 1) % 24;
        if (mh == 0) begin
          mdow = (mdow == 7) ? 1 : mdow + 1;
          if (mdate == days_in(mmon, myear)) begin
            mdate = 1; mmon++;
            if (mmon == 13) begin
              mmon = 1; myear++;
              if (myear == 100) begin myear = 0; mcent = ~mcent; end
            end
          end else mdate++;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    bit adv;
    if (!rst_n) begin
      ms = 0; mm = 0; mh = 0; m12 = 0; mdow = 1; mdate = 1; mmon = 1;
      myear = 0; mcent = 0; pc = 0; msq = 0; mstb = 0;
    end else begin
      adv = 0;
      if (osc_tick) begin
        if (pc == P - 1) begin pc = 0; adv = 1; end
        else pc++;
      end
      if (wr_en) begin
        adv = 0;
        case (wr_field)
          3'd0: begin ms = b2i(wr_data); pc = 0; end
          3'd1: mm = b2i(wr_data);
          3'd2: begin
            m12 = wr_data[6];
            if (wr_data[6]) mh = (b2i({3'b000, wr_data[4:0]}) % 12) + (wr_data[5] ? 12 : 0);
            else            mh = b2i({2'b00, wr_data[5:0]});
          end
          3'd3: mdow = b2i(wr_data);
          3'd4: mdate = b2i(wr_data);
          3'd5: begin mcent = wr_data[7]; mmon = b2i({3'b000, wr_data[4:0]}); end
          3'd6: myear = b2i(wr_data);
          default: ;
        endcase
      end
      if (adv) model_advance();
      mstb = adv;
      msq  = (pc >= P / 2);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "seconds", sec_bcd, i2b(ms));
      chk("R2", "minutes", min_bcd, i2b(mm));
      chk(m12 ? "R4" : "R3", "hours", hour_bcd, exp_hour());
      chk("R7", "dow", dow_bcd, i2b(mdow));
      chk("R5", "date", date_bcd, i2b(mdate));
      chk("R6", "month", month_bcd, {mcent, 2'b00, 5'(i2b(mmon))});
      chk("R6", "year", year_bcd, i2b(myear));
      chk("R11", "sq_1hz", {7'd0, sq_1hz}, {7'd0, msq});
      chk("R12", "strobe", {7'd0, sec_strobe}, {7'd0, mstb});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] f, input logic [7:0] d);
    wr_en = 1'b1; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                         input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] yr);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd3, dw); wr(3'd4, dt);
    wr(3'd5, mo); wr(3'd6, yr); wr(3'd0, s);
  endtask

  task automatic run_secs(input int n);
    repeat (n * P) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    int strobes;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sec", sec_bcd, 8'h00);
    chk("R1", "hour", hour_bcd, 8'h00);
    chk("R1", "dow", dow_bcd, 8'h01);
    chk("R1", "date", date_bcd, 8'h01);
    chk("R1", "month", month_bcd, 8'h01);
    chk("R1", "year", year_bcd, 8'h00);
    chk("R1", "strobe", {7'd0, sec_strobe}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sq", {7'd0, sq_1hz}, 8'h00);

    // R2 plain counting across a minute
    run_secs(70);
    chk("R2", "minute after 70s", min_bcd, 8'h01);

    // R3 and R7: end of day in 24-hour mode, dow 7 -> 1, non-leap Feb 28 -> Mar 1
    set_all(8'h23, 8'h59, 8'h58, 8'h07, 8'h28, 8'h02, 8'h23);
    run_secs(2);
    chk("R3", "hour wrap", hour_bcd, 8'h00);
    chk("R7", "dow wrap", dow_bcd, 8'h01);
    chk("R5", "non-leap feb", date_bcd, 8'h01);
    chk("R5", "march", month_bcd, 8'h03);

    // R5 leap year 24: Feb 28 -> 29
    set_all(8'h23, 8'h59, 8'h58, 8'h02, 8'h28, 8'h02, 8'h24);
    run_secs(2);
    chk("R5", "leap 29", date_bcd, 8'h29);
    // R5 year 00 leap: Feb 29 -> Mar 1
    set_all(8'h23, 8'h59, 8'h58, 8'h02, 8'h29, 8'h02, 8'h00);
    run_secs(2);
    chk("R5", "year00 feb29 end", date_bcd, 8'h01);
    // R5 thirty-day month
    set_all(8'h23, 8'h59, 8'h58, 8'h02, 8'h30, 8'h04, 8'h31);
    run_secs(2);
    chk("R5", "april end", month_bcd, 8'h05);
    // R5 month 09 -> 10 BCD carry
    set_all(8'h23, 8'h59, 8'h58, 8'h02, 8'h30, 8'h09, 8'h31);
    run_secs(2);
    chk("R5", "sept end", month_bcd, 8'h10);

    // R6 year 99 -> 00 with century flip
    set_all(8'h23, 8'h59, 8'h58, 8'h03, 8'h31, 8'h12, 8'h99);
    run_secs(2);
    chk("R6", "year wrap", year_bcd, 8'h00);
    chk("R6", "century set", month_bcd, 8'h81);

    // R4 12-hour mode transitions
    set_all(8'h51, 8'h59, 8'h58, 8'h04, 8'h10, 8'h06, 8'h25);
    run_secs(2);
    chk("R4", "11AM->12PM", hour_bcd, 8'h72);
    chk("R4", "no day step at noon", date_bcd, 8'h10);
    wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    run_secs(2);
    chk("R4", "12PM->01PM", hour_bcd, 8'h61);
    set_all(8'h71, 8'h59, 8'h58, 8'h04, 8'h10, 8'h06, 8'h25);
    run_secs(2);
    chk("R4", "11PM->12AM", hour_bcd, 8'h52);
    chk("R4", "day step at midnight", date_bcd, 8'h11);

    // R8 enable gaps
    held = sec_bcd;
    osc_tick = 1'b0;
    repeat (3 * P) @(negedge clk);
    chk("R8", "frozen while idle", sec_bcd, held);
    for (int i = 0; i < 40 * P; i++) begin
      osc_tick = ((i * 7) % 5) != 0;
      @(negedge clk);
    end
    osc_tick = 1'b1;

    // R9 write colliding with end of a second drops that advance
    while (pc != P - 1) @(negedge clk);
    held = sec_bcd;
    wr(3'd1, 8'h30);
    chk("R9", "advance dropped", sec_bcd, held);
    chk("R9", "minutes loaded", min_bcd, 8'h30);

    // R10 seconds write restarts prescaler
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h10);
    chk("R10", "sq low after write", {7'd0, sq_1hz}, 8'h00);
    repeat (P / 2 - 1) @(negedge clk);
    chk("R10", "sq still low", {7'd0, sq_1hz}, 8'h00);
    @(negedge clk);
    chk("R10", "sq high at half", {7'd0, sq_1hz}, 8'h01);
    repeat (P / 2 - 1) @(negedge clk);
    chk("R10", "no advance yet", sec_bcd, 8'h10);
    @(negedge clk);
    chk("R10", "advance after full period", sec_bcd, 8'h11);

    // R12 strobe count over five seconds
    strobes = 0;
    repeat (5 * P) begin
      @(negedge clk);
      if (sec_strobe) strobes++;
    end
    chk("R12", "strobes in 5s", 8'(strobes), 8'd5);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule